// File: doc/BRIEF.md
# Two-Phase CDR Lock Sequencer

This block is the control state machine for a baud-rate clock recovery loop in a four-level (PAM4) receiver. It chooses how the timing-error comparator slices the signal, and it decides the order in which the adaptation engines run. The sequence deliberately acquires lock with a binary timing decision first. Transitions between the two outer levels can look like full swings to a four-level detector, and that can pull the loop onto a false lock point. Acquiring lock on binary decisions first avoids this.

After a start request, the sequencer selects binary slicing and enables every adaptation engine: equalizer, gain and comparator thresholds. Once that adaptation finishes, it waits for the loop to report lock. It then switches the comparator to four-level slicing and runs equalizer and threshold adaptation again. Finally, it enters tracking, where the recovered clock is fine-tuned on four-level decisions.

Lock is judged from a per-window phase-error accumulator. If lock does not arrive in time in either lock-wait phase, the sequencer restarts from binary adaptation and counts the retry. The phase detector, loop filter and adaptation engines sit outside this block.

Top module: `cdr_lock_seq`

## Requirements
- R1: After synchronous reset the state code is 0 (idle). The comparator mode is binary (`cmp_pam4`=0), all adaptation enables and `track_en` are low, `retry_cnt` is 0 and `locked` is 0.
- R2: In idle, with `en` high, a cycle with `start` high moves the block to state code 1 (binary adapt) at the next edge. In that state the mode is binary and `eq_adapt_en`, `gain_adapt_en` and `thr_adapt_en` are all high.
- R3: Binary adapt ends at the edge of the first cycle in which `eq_done`, `gain_done` and `thr_done` are all high, or after `ADAPT_BUDGET` cycles in the state, whichever comes first. The next state is code 2 (binary lock wait): binary mode, all enables low.
- R4: In a lock-wait state (codes 2 and 4), each cycle with `win_valid` high counts one window. A window whose two's-complement `pe_acc` has a magnitude strictly below `lock_thr` adds one to a consecutive run. Any other window resets the run to zero. Lock holds while the run is at least `lock_req`, and a `lock_req` of 0 acts as 1. The run is cleared while the block is in any other state.
- R5: Code 3 (four-level adapt) is entered only from code 2, at the edge after a cycle in which lock holds. In code 3, `cmp_pam4`=1, `eq_adapt_en`=1, `thr_adapt_en`=1 and `gain_adapt_en`=0.
- R6: Four-level adapt ends at the edge of the first cycle with `eq_done` and `thr_done` both high, or after `ADAPT_BUDGET` cycles, whichever comes first. The next state is code 4 (tracking): `cmp_pam4`=1, `track_en`=1, adaptation enables low.
- R7: In tracking, a cycle in which lock holds sets `locked` at the next edge. After that the block stays in tracking with `locked` high for as long as `en` stays high.
- R8: A lock-wait state that lasts `lock_timeout` cycles without lock returns to code 1. A `lock_timeout` of 0 acts as 1. On that return `retry_cnt` rises by one, saturating at its maximum. Lock in the last allowed cycle takes priority over the timeout.
- R9: `en` low in any cycle returns the block to idle at the next edge, with every R1 output value except `retry_cnt`. `start` has no effect while `en` is low or outside idle.
- R10: `retry_cnt` clears to 0 when a start request is accepted from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sequencer enable; low forces idle |
| start | input | 1 | Start request, accepted in idle |
| eq_done | input | 1 | Equalizer adaptation done flag |
| gain_done | input | 1 | Gain adaptation done flag |
| thr_done | input | 1 | Comparator threshold adaptation done flag |
| win_valid | input | 1 | Phase-error window strobe |
| pe_acc | input | PE_W | Two's-complement phase-error accumulator for the window |
| lock_thr | input | PE_W | Unsigned lock magnitude threshold |
| lock_req | input | CNT_W | Consecutive quiet windows needed for lock |
| lock_timeout | input | TO_W | Lock-wait timeout in cycles |
| cmp_pam4 | output | 1 | Timing comparator mode: 0 binary, 1 four-level |
| eq_adapt_en | output | 1 | Equalizer adaptation enable |
| gain_adapt_en | output | 1 | Gain adaptation enable |
| thr_adapt_en | output | 1 | Threshold adaptation enable |
| track_en | output | 1 | Fine phase tracking enable |
| locked | output | 1 | Lock reached in tracking |
| retry_cnt | output | RETRY_W | Saturating count of timeouts |
| state_code | output | 3 | Current state code (0 to 4) |

## Verification
A corrupted state register shows up in `state_code` and in the mode and enable outputs in the same cycle, because those outputs decode the state directly. A miscounted cycle timer moves the adapt-to-lock or timeout transition by at least one edge, and this becomes visible exactly `ADAPT_BUDGET` or `lock_timeout` cycles after the state was entered. An error in the window run counter changes the edge at which four-level mode begins, or whether `locked` rises. This is caught on the cycle after the deciding window, because a model of the sequence is compared with every output on every cycle.

// File: rtl/cdr_seq_pkg.sv
`timescale 1ns/1ps
package cdr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_NRZ_ADAPT  = 3'd1,
        ST_NRZ_LOCK   = 3'd2,
        ST_PAM4_ADAPT = 3'd3,
        ST_TRACK      = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic cmp_pam4;
        logic eq_en;
        logic gain_en;
        logic thr_en;
        logic track_en;
    } seq_ctrl_t;

    // Output decode per state: mode select and adaptation enables.
    function automatic seq_ctrl_t ctrl_of(seq_state_e s);
        seq_ctrl_t c;
        c = '0;
        case (s)
            ST_NRZ_ADAPT: begin
                c.eq_en   = 1'b1;
                c.gain_en = 1'b1;
                c.thr_en  = 1'b1;
            end
            ST_PAM4_ADAPT: begin
                c.cmp_pam4 = 1'b1;
                c.eq_en    = 1'b1;
                c.thr_en   = 1'b1;
            end
            ST_TRACK: begin
                c.cmp_pam4 = 1'b1;
                c.track_en = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_lock_wait(seq_state_e s);
        return (s == ST_NRZ_LOCK) || (s == ST_TRACK);
    endfunction

endpackage

// File: rtl/cdr_lock_det.sv
`timescale 1ns/1ps
module cdr_lock_det #(
    parameter int PE_W  = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             win_valid_i,
    input  logic [PE_W-1:0]  pe_acc_i,
    input  logic [PE_W-1:0]  thr_i,
    input  logic [CNT_W-1:0] req_i,
    output logic             lock_o
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

    logic [PE_W-1:0]  mag;
    logic             quiet;
    logic [CNT_W-1:0] eff_req;
    logic [CNT_W-1:0] run_q;

    always_comb begin
        mag     = pe_acc_i[PE_W-1] ? (~pe_acc_i + 1'b1) : pe_acc_i;
        quiet   = (mag < thr_i);
        eff_req = (req_i == '0) ? RUN_ONE : req_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            run_q <= '0;
        end else if (win_valid_i) begin
            if (!quiet)
                run_q <= '0;
            else if (run_q != RUN_MAX)
                run_q <= run_q + 1'b1;
        end
    end

    assign lock_o = (run_q >= eff_req);

    // R4: a cleared run cannot report lock on the next cycle
    a_r4_clear_drops_lock: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !lock_o);

    // R4: a loud window breaks the run
    a_r4_loud_breaks_run: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && win_valid_i && !quiet) |=> !lock_o);

endmodule

// File: rtl/cdr_seq_timer.sv
`timescale 1ns/1ps
module cdr_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R3: time in state advances one per cycle until saturation
    a_r3_timer_steps: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/cdr_seq_fsm.sv
`timescale 1ns/1ps
module cdr_seq_fsm
    import cdr_seq_pkg::*;
#(
    parameter int TO_W         = 16,
    parameter int RETRY_W      = 4,
    parameter int ADAPT_BUDGET = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic               start_i,
    input  logic               nrz_done_i,
    input  logic               pam4_done_i,
    input  logic               lock_i,
    input  logic [TO_W-1:0]    tcnt_i,
    input  logic [TO_W-1:0]    timeout_i,
    output seq_state_e         state_o,
    output logic [RETRY_W-1:0] retry_o,
    output logic               tlock_o,
    output logic               tclr_o
);
    localparam logic [TO_W-1:0]    BUDGET_LAST = TO_W'(ADAPT_BUDGET - 1);
    localparam logic [RETRY_W-1:0] RETRY_MAX   = {RETRY_W{1'b1}};

    seq_state_e         state_q, state_d;
    logic [RETRY_W-1:0] retry_q, retry_d, retry_inc;
    logic               tlock_q, tlock_d;
    logic [TO_W-1:0]    timeout_last;
    logic               budget_hit, timeout_hit;

    always_comb begin
        timeout_last = (timeout_i == '0) ? '0 : timeout_i - 1'b1;
        budget_hit   = (tcnt_i == BUDGET_LAST);
        timeout_hit  = (tcnt_i == timeout_last);
        retry_inc    = (retry_q == RETRY_MAX) ? retry_q : retry_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        retry_d = retry_q;
        tlock_d = 1'b0;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_d = ST_NRZ_ADAPT;
                        retry_d = '0;
                    end
                end
                ST_NRZ_ADAPT: begin
                    if (nrz_done_i || budget_hit)
                        state_d = ST_NRZ_LOCK;
                end
                ST_NRZ_LOCK: begin
                    if (lock_i) begin
                        state_d = ST_PAM4_ADAPT;
                    end else if (timeout_hit) begin
                        state_d = ST_NRZ_ADAPT;
                        retry_d = retry_inc;
                    end
                end
                ST_PAM4_ADAPT: begin
                    if (pam4_done_i || budget_hit)
                        state_d = ST_TRACK;
                end
                ST_TRACK: begin
                    if (tlock_q || lock_i) begin
                        tlock_d = 1'b1;
                    end else if (timeout_hit) begin
                        state_d = ST_NRZ_ADAPT;
                        retry_d = retry_inc;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            retry_q <= '0;
            tlock_q <= 1'b0;
        end else begin
            state_q <= state_d;
            retry_q <= retry_d;
            tlock_q <= tlock_d;
        end
    end

    assign state_o = state_q;
    assign retry_o = retry_q;
    assign tlock_o = tlock_q;
    assign tclr_o  = (state_d != state_q);

    // R5: four-level mode never entered from binary lock wait without lock
    a_r5_pam4_needs_lock: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NRZ_LOCK && !lock_i) |=> (state_q != ST_PAM4_ADAPT));

    // R9: enable low forces idle at the next edge
    a_r9_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (state_q == ST_IDLE));

    // R8: retry count only steps by one or clears
    a_r8_retry_step: assert property (@(posedge clk) disable iff (rst)
        (retry_q != $past(retry_q)) |->
            ((retry_q == $past(retry_q) + 1'b1) || (retry_q == '0)));

    // R7: once locked in tracking, stay in tracking while enabled
    a_r7_lock_sticks: assert property (@(posedge clk) disable iff (rst)
        (tlock_q && en_i) |=> (state_q == ST_TRACK && tlock_q));

endmodule

// File: rtl/cdr_lock_seq.sv
`timescale 1ns/1ps
module cdr_lock_seq
    import cdr_seq_pkg::*;
#(
    parameter int PE_W         = 12,
    parameter int CNT_W        = 8,
    parameter int TO_W         = 16,
    parameter int RETRY_W      = 4,
    parameter int ADAPT_BUDGET = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               start,
    input  logic               eq_done,
    input  logic               gain_done,
    input  logic               thr_done,
    input  logic               win_valid,
    input  logic [PE_W-1:0]    pe_acc,
    input  logic [PE_W-1:0]    lock_thr,
    input  logic [CNT_W-1:0]   lock_req,
    input  logic [TO_W-1:0]    lock_timeout,
    output logic               cmp_pam4,
    output logic               eq_adapt_en,
    output logic               gain_adapt_en,
    output logic               thr_adapt_en,
    output logic               track_en,
    output logic               locked,
    output logic [RETRY_W-1:0] retry_cnt,
    output logic [2:0]         state_code
);
    seq_state_e      state;
    seq_ctrl_t       ctrl;
    logic            lock_now;
    logic            det_clr;
    logic            tclr;
    logic [TO_W-1:0] tcnt;
    logic            nrz_done, pam4_done;

    assign nrz_done  = eq_done & gain_done & thr_done;
    assign pam4_done = eq_done & thr_done;
    assign det_clr   = !is_lock_wait(state);

    cdr_lock_det #(.PE_W(PE_W), .CNT_W(CNT_W)) lock_det_i (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (det_clr),
        .win_valid_i (win_valid),
        .pe_acc_i    (pe_acc),
        .thr_i       (lock_thr),
        .req_i       (lock_req),
        .lock_o      (lock_now)
    );

    cdr_seq_timer #(.W(TO_W)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tclr),
        .cnt_o (tcnt)
    );

    cdr_seq_fsm #(
        .TO_W(TO_W), .RETRY_W(RETRY_W), .ADAPT_BUDGET(ADAPT_BUDGET)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en),
        .start_i     (start),
        .nrz_done_i  (nrz_done),
        .pam4_done_i (pam4_done),
        .lock_i      (lock_now),
        .tcnt_i      (tcnt),
        .timeout_i   (lock_timeout),
        .state_o     (state),
        .retry_o     (retry_cnt),
        .tlock_o     (locked),
        .tclr_o      (tclr)
    );

    assign ctrl          = ctrl_of(state);
    assign cmp_pam4      = ctrl.cmp_pam4;
    assign eq_adapt_en   = ctrl.eq_en;
    assign gain_adapt_en = ctrl.gain_en;
    assign thr_adapt_en  = ctrl.thr_en;
    assign track_en      = ctrl.track_en;
    assign state_code    = state;

    // R2: accepted start enables full adaptation in binary mode
    a_r2_start_adapts: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0 && en && start) |=>
            (eq_adapt_en && gain_adapt_en && thr_adapt_en && !cmp_pam4));

    // R6: tracking is entered only from four-level adapt
    a_r6_track_entry: assert property (@(posedge clk) disable iff (rst)
        (state_code != 3'd3 && state_code != 3'd4) |=> !track_en);

endmodule

// File: tb/cdr_lock_seq_tb.sv
`timescale 1ns/1ps
module cdr_lock_seq_tb_top;
    localparam int PE_W    = 12;
    localparam int CNT_W   = 8;
    localparam int TO_W    = 16;
    localparam int RETRY_W = 4;
    localparam int BUDGET  = 64;
    localparam int RMAX    = (1 << RETRY_W) - 1;
    localparam int LMAX    = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, start = 1'b0;
    logic eq_done = 1'b0, gain_done = 1'b0, thr_done = 1'b0;
    logic win_valid = 1'b0;
    logic [PE_W-1:0]  pe_acc = '0;
    logic [PE_W-1:0]  lock_thr = 12'd50;
    logic [CNT_W-1:0] lock_req = 8'd3;
    logic [TO_W-1:0]  lock_timeout = 16'd30;
    logic cmp_pam4, eq_adapt_en, gain_adapt_en, thr_adapt_en, track_en, locked;
    logic [RETRY_W-1:0] retry_cnt;
    logic [2:0] state_code;

    always #2.5 clk = ~clk;

    cdr_lock_seq #(.PE_W(PE_W), .CNT_W(CNT_W), .TO_W(TO_W),
                   .RETRY_W(RETRY_W), .ADAPT_BUDGET(BUDGET)) dut_i (
        .clk(clk), .rst(rst), .en(en), .start(start),
        .eq_done(eq_done), .gain_done(gain_done), .thr_done(thr_done),
        .win_valid(win_valid), .pe_acc(pe_acc), .lock_thr(lock_thr),
        .lock_req(lock_req), .lock_timeout(lock_timeout),
        .cmp_pam4(cmp_pam4), .eq_adapt_en(eq_adapt_en),
        .gain_adapt_en(gain_adapt_en), .thr_adapt_en(thr_adapt_en),
        .track_en(track_en), .locked(locked), .retry_cnt(retry_cnt),
        .state_code(state_code)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // reference model state
    int m_state = 0, m_tcnt = 0, m_lcnt = 0, m_retry = 0;
    bit m_tlock = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // expected {cmp, eq, gain, thr, track} for a state code
    function automatic int exp_ctrl(int s);
        case (s)
            1: return 5'b01110;
            3: return 5'b11010;
            4: return 5'b10001;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic int pe_mag(logic [PE_W-1:0] v);
        logic [PE_W-1:0] m;
        m = v[PE_W-1] ? (~v + 1'b1) : v;
        return int'(m);
    endfunction

    task automatic model_step();
        int ns, nt, nl, nr;
        bit ntl, lk;
        int req, tlast;
        req   = (lock_req == 0) ? 1 : int'(lock_req);
        tlast = (lock_timeout == 0) ? 0 : int'(lock_timeout) - 1;
        lk    = (m_lcnt >= req);
        ns = m_state; nr = m_retry; ntl = 1'b0;
        if (rst) begin
            m_state = 0; m_tcnt = 0; m_lcnt = 0; m_retry = 0; m_tlock = 0;
            return;
        end
        if (!en) ns = 0;
        else case (m_state)
            0: if (start) begin ns = 1; nr = 0; end
            1: if ((eq_done && gain_done && thr_done) || m_tcnt == BUDGET-1) ns = 2;
            2: if (lk) ns = 3;
               else if (m_tcnt == tlast) begin ns = 1; nr = (m_retry == RMAX) ? RMAX : m_retry + 1; end
            3: if ((eq_done && thr_done) || m_tcnt == BUDGET-1) ns = 4;
            4: if (m_tlock || lk) ntl = 1'b1;
               else if (m_tcnt == tlast) begin ns = 1; nr = (m_retry == RMAX) ? RMAX : m_retry + 1; end
            default: ns = 0;
        endcase
        nt = (ns != m_state) ? 0 : ((m_tcnt == 65535) ? m_tcnt : m_tcnt + 1);
        if (m_state != 2 && m_state != 4) nl = 0;
        else if (win_valid) nl = (pe_mag(pe_acc) < int'(lock_thr)) ? ((m_lcnt == LMAX) ? LMAX : m_lcnt + 1) : 0;
        else nl = m_lcnt;
        m_state = ns; m_tcnt = nt; m_lcnt = nl; m_retry = nr; m_tlock = ntl;
    endtask

    task automatic compare_all();
        string t;
        t = tag_of(m_state);
        chk(t, "state_code", int'(state_code), m_state);
        chk(t, "ctrl", int'({cmp_pam4, eq_adapt_en, gain_adapt_en, thr_adapt_en, track_en}),
            exp_ctrl(m_state));
        chk("R8", "retry_cnt", int'(retry_cnt), m_retry);
        chk("R7", "locked", int'(locked), int'(m_tlock));
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(posedge clk);
            #1;
            compare_all();
        end
    endtask

    task automatic win(logic [PE_W-1:0] v);
        win_valid = 1'b1; pe_acc = v;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1", "idle after reset", int'(state_code), 0);
        chk("R1", "retry after reset", int'(retry_cnt), 0);

        // start while disabled is ignored
        start = 1'b1; tick(2);
        chk("R9", "start with en low", int'(state_code), 0);

        en = 1'b1; tick(1);
        chk("R2", "binary adapt entered", int'(state_code), 1);
        chk("R2", "gain enable", int'(gain_adapt_en), 1);
        start = 1'b0;
        eq_done = 1'b1; gain_done = 1'b1; tick(2);
        chk("R3", "partial done holds", int'(state_code), 1);
        thr_done = 1'b1; tick(1);
        chk("R3", "all done ends adapt", int'(state_code), 2);
        eq_done = 1'b0; gain_done = 1'b0; thr_done = 1'b0;

        win(12'd10); tick(2);
        win(-12'sd60); tick(1);
        chk("R4", "loud window resets run", int'(state_code), 2);
        win(-12'sd49); tick(3);
        chk("R4", "lock pending one edge", int'(state_code), 2);
        win_valid = 1'b0; tick(1);
        chk("R5", "four-level adapt", int'(state_code), 3);
        chk("R5", "mode four-level", int'(cmp_pam4), 1);
        chk("R5", "gain off", int'(gain_adapt_en), 0);

        tick(BUDGET - 1);
        chk("R6", "budget not yet spent", int'(state_code), 3);
        tick(1);
        chk("R6", "budget ends adapt", int'(state_code), 4);
        chk("R6", "track enable", int'(track_en), 1);

        win(12'd0); tick(3);
        chk("R7", "not yet locked", int'(locked), 0);
        win_valid = 1'b0; tick(1);
        chk("R7", "locked in tracking", int'(locked), 1);
        tick(100);
        chk("R7", "stays tracking", int'(state_code), 4);

        en = 1'b0; tick(1);
        chk("R9", "disable to idle", int'(state_code), 0);
        chk("R9", "track off", int'(track_en), 0);
        en = 1'b1; start = 1'b1; tick(1); start = 1'b0;
        eq_done = 1'b1; gain_done = 1'b1; thr_done = 1'b1; tick(1);
        eq_done = 1'b0; gain_done = 1'b0; thr_done = 1'b0;
        chk("R3", "lock wait", int'(state_code), 2);
        tick(29);
        chk("R8", "before timeout", int'(state_code), 2);
        tick(1);
        chk("R8", "timeout retry state", int'(state_code), 1);
        chk("R8", "retry count", int'(retry_cnt), 1);
        start = 1'b1; tick(1);
        chk("R9", "start outside idle", int'(retry_cnt), 1);
        en = 1'b0; tick(1);
        chk("R9", "retry held in idle", int'(retry_cnt), 1);
        en = 1'b1; tick(1); start = 1'b0;
        chk("R10", "retry cleared on start", int'(retry_cnt), 0);

        // constrained random segments
        for (int seg = 0; seg < 8; seg++) begin
            lock_req     = CNT_W'($urandom_range(0, 4));
            lock_timeout = TO_W'($urandom_range(0, 40));
            lock_thr     = PE_W'($urandom_range(20, 120));
            for (int c = 0; c < 1500; c++) begin
                en        = ($urandom_range(0, 99) < 97);
                start     = ($urandom_range(0, 99) < 10);
                eq_done   = ($urandom_range(0, 99) < 40);
                gain_done = ($urandom_range(0, 99) < 40);
                thr_done  = ($urandom_range(0, 99) < 40);
                win_valid = ($urandom_range(0, 99) < 60);
                if ($urandom_range(0, 99) < 75)
                    pe_acc = PE_W'($urandom_range(0, 60)) - PE_W'(30);
                else
                    pe_acc = PE_W'($urandom);
                tick(1);
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule